// File: doc/BRIEF.md
# Flash Chip-Select Segment Decoder

The block keeps one segment register for each flash chip select. A register describes the address range that its chip select owns inside a fixed flash window. The unit of both range limits is an 8 MB granule. Software programs the registers through a small indexed port. Each write is checked against a set of legality rules. Some writes are corrected, some are refused, and some are stored with a warning. Every outcome that is refused or only warned about sets a sticky flag, and the flag stays set until software clears it.

On the access side, each cycle can carry one lookup, in one of two forms. An absolute lookup takes a full bus address and reports every chip select whose range holds it, together with the byte offset into the lowest-numbered match. A direct lookup names a chip select and a raw offset. It reports that offset reduced modulo the segment size, and raises an error when the raw offset did not fit. The serial flash transfer that follows the lookup lies outside this block.

Top module: `flash_seg_decoder`

## Requirements
- R1: A segment register holds the end granule in bits [31:24] and the start granule in bits [23:16]. Bits [15:0] always read as zero. Granule g maps to byte address g<<23. After reset, CS0 spans [WIN_BASE_G, WIN_BASE_G+RST_SIZE0_G). Each later CS takes the next RST_SIZEN_G granules in order.
- R2: A read returns the addressed register one cycle after reg_idx is presented. An index of NUM_CS or above reads zero, and a write to it changes nothing and raises no flag.
- R3: The start field of CS0 cannot be changed. A write to CS0 stores WIN_BASE_G as the start and takes the end field from the written data.
- R4: A write is refused when its end granule is at or below WIN_BASE_G, or when its start granule is above WIN_BASE_G+WIN_SIZE_G. A refused write keeps the old register value and sets status bit 0. A start exactly at WIN_BASE_G+WIN_SIZE_G is accepted.
- R5: A segment's size is end minus start when end exceeds start, and zero otherwise. An accepted write with a nonzero size and a start that is not a multiple of that size sets status bit 1 and is still stored.
- R6: An accepted write whose half-open range [start, start+size) intersects the range of any other chip select sets status bit 2 and is still stored. Ranges that only touch do not intersect.
- R7: A write whose bits [31:16] equal the current register contents is ignored: nothing changes and no flag is raised.
- R8: Status flags are visible on sts_flags in the cycle after the write that causes them. They stay set until a cycle with sts_clr_en high and a 1 in the matching sts_clr_mask bit. A new event in that same cycle wins over the clear.
- R9: An absolute lookup (acc_direct=0) sets out_hit bit i for every CS with start_i <= acc_addr>>23 < end_i. The offset is acc_addr minus the start address of the lowest set bit. When no CS matches, the result is hit 0, offset 0, error 1. Results appear with out_valid one cycle after acc_valid, and all outputs are zero in cycles without a lookup.
- R10: A direct lookup (acc_direct=1) sets only the out_hit bit of acc_cs. It returns acc_addr modulo the segment size and sets out_err when acc_addr is at least the size. A zero-size segment or an acc_cs of NUM_CS or above gives offset 0 and error 1.
- R11: The modulo of R10 is correct for segment sizes that are not powers of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Segment register write strobe |
| reg_idx | input | IDXW | Chip-select index for read and write |
| reg_wdata | input | 32 | Write data in the segment encoding |
| reg_rdata | output | 32 | Registered read data |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_mask | input | 3 | Write-1-to-clear mask for the status flags |
| sts_flags | output | 3 | Sticky flags: bit0 refused, bit1 misaligned, bit2 overlap |
| acc_valid | input | 1 | Lookup request |
| acc_direct | input | 1 | 0 absolute address, 1 chip select plus raw offset |
| acc_cs | input | IDXW | Chip select for a direct lookup |
| acc_addr | input | 32 | Bus address or raw offset |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | NUM_CS | Matching chip selects |
| out_off | output | 32 | Offset within the segment |
| out_err | output | 1 | Lookup miss or out-of-range offset |

## Verification
The in-RTL assertions watch several rules on every cycle. CS0 must always keep its fixed start and every register its zero low half. A refused or repeated write must leave its register untouched. Flags must never drop without a clear, and any event must appear as a flag. Lookup outputs must be quiet when idle, a direct lookup may mark at most one chip select, and an error-free result must carry a hit. Only the bench scenarios can show the actual values: the corrected CS0 word, the range boundaries, the misalignment and overlap decisions, the lowest-index offset when segments overlap, and the modulo results for power-of-two and other sizes.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
  localparam int ADDR_W     = 32;
  localparam int GRAN_SHIFT = 23;
  localparam int GRAN_W     = 8;
  localparam int AG_W       = ADDR_W - GRAN_SHIFT;
  localparam int NERR       = 3;
  localparam int ERR_RANGE  = 0;
  localparam int ERR_ALIGN  = 1;
  localparam int ERR_OVLP   = 2;

  typedef logic [GRAN_W-1:0] gran_t;
  typedef logic [AG_W-1:0]   agran_t;

  // empty segment when end does not exceed start
  function automatic gran_t seg_size(input gran_t s, input gran_t e);
    return (e > s) ? gran_t'(e - s) : '0;
  endfunction

  // restoring division remainder, one step per numerator bit
  function automatic agran_t gran_mod(input agran_t num, input gran_t den);
    agran_t rem;
    rem = '0;
    for (int b = AG_W - 1; b >= 0; b--) begin
      rem = {rem[AG_W-2:0], num[b]};
      if (rem >= {1'b0, den}) rem = rem - {1'b0, den};
    end
    return rem;
  endfunction

  function automatic logic is_pow2(input gran_t v);
    return (v != '0) && ((v & gran_t'(v - 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_dec_pkg::*;
#(
  parameter int NUM_CS      = 3,
  parameter int IDXW        = 2,
  parameter int WIN_BASE_G  = 'h40,
  parameter int WIN_SIZE_G  = 32,
  parameter int RST_SIZE0_G = 8,
  parameter int RST_SIZEN_G = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDXW-1:0]              idx,
  input  logic [31:0]                  wr_data,
  output logic [31:0]                  rd_data,
  output logic [NUM_CS-1:0][GRAN_W-1:0] seg_start_o,
  output logic [NUM_CS-1:0][GRAN_W-1:0] seg_end_o,
  output logic [NERR-1:0]              evt_o
);
  localparam int    WIN_LAST_G = WIN_BASE_G + WIN_SIZE_G;
  localparam gran_t BASE_G     = gran_t'(WIN_BASE_G);

  function automatic logic [31:0] rst_word(input int i);
    int s, e;
    s = (i == 0) ? WIN_BASE_G : WIN_BASE_G + RST_SIZE0_G + (i - 1) * RST_SIZEN_G;
    e = s + ((i == 0) ? RST_SIZE0_G : RST_SIZEN_G);
    return {e[7:0], s[7:0], 16'h0000};
  endfunction

  logic [31:0] regs_q [NUM_CS];
  logic [31:0] cur_word, new_word;
  logic        idx_ok, same, reject, misal, ovlp, do_wr;
  gran_t       new_start, new_end, new_size, new_last;
  logic        unused_low;

  assign unused_low = ^wr_data[15:0];

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_out
      assign seg_start_o[g] = regs_q[g][23:16];
      assign seg_end_o[g]   = regs_q[g][31:24];
    end
  endgenerate

  always_comb begin
    idx_ok   = 1'b0;
    cur_word = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (idx == IDXW'(i)) begin
        idx_ok   = 1'b1;
        cur_word = regs_q[i];
      end
    end
    same      = idx_ok && ({wr_data[31:16], 16'h0000} == cur_word);
    new_end   = wr_data[31:24];
    new_start = (idx == '0) ? BASE_G : wr_data[23:16];
    new_word  = {new_end, new_start, 16'h0000};
    new_size  = seg_size(new_start, new_end);
    new_last  = gran_t'(new_start + new_size);
    reject    = (new_end <= BASE_G) || (int'(new_start) > WIN_LAST_G);
    misal     = (new_size != '0) &&
                (gran_mod({1'b0, new_start}, new_size) != '0);
    ovlp      = 1'b0;
    for (int j = 0; j < NUM_CS; j++) begin
      if (idx != IDXW'(j)) begin
        if ((new_start < gran_t'(seg_start_o[j] + seg_size(seg_start_o[j], seg_end_o[j]))) &&
            (new_last > seg_start_o[j]))
          ovlp = 1'b1;
      end
    end
    do_wr = wr_en && idx_ok && !same;
    evt_o = '0;
    evt_o[ERR_RANGE] = do_wr && reject;
    evt_o[ERR_ALIGN] = do_wr && !reject && misal;
    evt_o[ERR_OVLP]  = do_wr && !reject && ovlp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CS; i++) regs_q[i] <= rst_word(i);
      rd_data <= '0;
    end else begin
      for (int i = 0; i < NUM_CS; i++)
        if (do_wr && !reject && idx == IDXW'(i)) regs_q[i] <= new_word;
      rd_data <= cur_word;
    end
  end

  // R3
  cs0_start_ro_chk: assert property (@(posedge clk) disable iff (rst)
    regs_q[0][23:16] == BASE_G);

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_chk
      // R1
      low_half_zero_chk: assert property (@(posedge clk) disable iff (rst)
        regs_q[g][15:0] == 16'h0000);
      // R4
      refused_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IDXW'(g) && reject) |=> (regs_q[g] == $past(regs_q[g])));
      // R7
      same_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IDXW'(g) && same) |=> (regs_q[g] == $past(regs_q[g])));
    end
  endgenerate
endmodule

// File: rtl/seg_err_status.sv
module seg_err_status
  import seg_dec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NERR-1:0] evt_i,
  input  logic            clr_en,
  input  logic [NERR-1:0] clr_mask,
  output logic [NERR-1:0] flags_o
);
  logic [NERR-1:0] clr_bits;
  assign clr_bits = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (flags_o & ~clr_bits) | evt_i;
  end

  generate
    for (genvar k = 0; k < NERR; k++) begin : g_chk
      // R8
      flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_o[k] && !clr_bits[k]) |=> flags_o[k]);
      // R8
      event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i[k] |=> flags_o[k]);
    end
  endgenerate
endmodule

// File: rtl/seg_map_lookup.sv
module seg_map_lookup
  import seg_dec_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int IDXW   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          acc_valid,
  input  logic                          acc_direct,
  input  logic [IDXW-1:0]               acc_cs,
  input  logic [31:0]                   acc_addr,
  input  logic [NUM_CS-1:0][GRAN_W-1:0] seg_start_i,
  input  logic [NUM_CS-1:0][GRAN_W-1:0] seg_end_i,
  output logic                          valid_o,
  output logic [NUM_CS-1:0]             hit_o,
  output logic [31:0]                   off_o,
  output logic                          err_o
);
  agran_t               ag, rem;
  logic [GRAN_SHIFT-1:0] lo;
  logic [NUM_CS-1:0]    hit_abs, hit_dir, hit_n;
  gran_t                sel_start, dsize, dstart, dend;
  logic                 any_abs, cs_ok, err_n;
  logic [31:0]          off_n;

  assign ag = acc_addr[31:GRAN_SHIFT];
  assign lo = acc_addr[GRAN_SHIFT-1:0];

  always_comb begin
    hit_abs   = '0;
    any_abs   = 1'b0;
    sel_start = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      hit_abs[i] = (ag >= {1'b0, seg_start_i[i]}) && (ag < {1'b0, seg_end_i[i]});
      if (hit_abs[i]) begin
        any_abs   = 1'b1;
        sel_start = seg_start_i[i];
      end
    end
    cs_ok   = 1'b0;
    dstart  = '0;
    dend    = '0;
    hit_dir = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (acc_cs == IDXW'(i)) begin
        cs_ok      = 1'b1;
        dstart     = seg_start_i[i];
        dend       = seg_end_i[i];
        hit_dir[i] = 1'b1;
      end
    end
    dsize = seg_size(dstart, dend);
    rem   = is_pow2(dsize) ? (ag & {1'b0, gran_t'(dsize - 1'b1)})
                           : gran_mod(ag, dsize);
    if (acc_direct) begin
      hit_n = hit_dir;
      if (!cs_ok || dsize == '0) begin
        off_n = '0;
        err_n = 1'b1;
      end else begin
        off_n = {rem, lo};
        err_n = ag >= {1'b0, dsize};
      end
    end else begin
      hit_n = hit_abs;
      off_n = any_abs ? {agran_t'(ag - {1'b0, sel_start}), lo} : '0;
      err_n = !any_abs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !acc_valid) begin
      valid_o <= 1'b0;
      hit_o   <= '0;
      off_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b1;
      hit_o   <= hit_n;
      off_o   <= off_n;
      err_o   <= err_n;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (hit_o == '0 && off_o == '0 && !err_o));
  // R9
  clean_has_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !err_o) |-> (hit_o != '0));
  // R10
  direct_single_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_direct) |=> $onehot0(hit_o));
endmodule

// File: rtl/flash_seg_decoder.sv
module flash_seg_decoder
  import seg_dec_pkg::*;
#(
  parameter int NUM_CS      = 3,
  parameter int IDXW        = (NUM_CS > 1) ? $clog2(NUM_CS + 1) : 1,
  parameter int WIN_BASE_G  = 'h40,
  parameter int WIN_SIZE_G  = 32,
  parameter int RST_SIZE0_G = 8,
  parameter int RST_SIZEN_G = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [IDXW-1:0]   reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sts_clr_en,
  input  logic [2:0]        sts_clr_mask,
  output logic [2:0]        sts_flags,
  input  logic              acc_valid,
  input  logic              acc_direct,
  input  logic [IDXW-1:0]   acc_cs,
  input  logic [31:0]       acc_addr,
  output logic              out_valid,
  output logic [NUM_CS-1:0] out_hit,
  output logic [31:0]       out_off,
  output logic              out_err
);
  logic [NUM_CS-1:0][GRAN_W-1:0] seg_start, seg_end;
  logic [NERR-1:0]               evt;

  seg_reg_file #(
    .NUM_CS(NUM_CS), .IDXW(IDXW), .WIN_BASE_G(WIN_BASE_G),
    .WIN_SIZE_G(WIN_SIZE_G), .RST_SIZE0_G(RST_SIZE0_G), .RST_SIZEN_G(RST_SIZEN_G)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .idx(reg_idx), .wr_data(reg_wdata),
    .rd_data(reg_rdata), .seg_start_o(seg_start), .seg_end_o(seg_end), .evt_o(evt)
  );

  seg_err_status u_status (
    .clk(clk), .rst(rst), .evt_i(evt), .clr_en(sts_clr_en),
    .clr_mask(sts_clr_mask), .flags_o(sts_flags)
  );

  seg_map_lookup #(.NUM_CS(NUM_CS), .IDXW(IDXW)) u_lookup (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_direct(acc_direct),
    .acc_cs(acc_cs), .acc_addr(acc_addr), .seg_start_i(seg_start),
    .seg_end_i(seg_end), .valid_o(out_valid), .hit_o(out_hit),
    .off_o(out_off), .err_o(out_err)
  );
endmodule

// File: tb/flash_seg_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_seg_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sts_clr_en = 1'b0;
  logic [2:0]  sts_clr_mask = '0;
  logic [2:0]  sts_flags;
  logic        acc_valid = 1'b0;
  logic        acc_direct = 1'b0;
  logic [1:0]  acc_cs = '0;
  logic [31:0] acc_addr = '0;
  logic        out_valid;
  logic [2:0]  out_hit;
  logic [31:0] out_off;
  logic        out_err;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_seg_decoder dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sts_clr_en(sts_clr_en),
    .sts_clr_mask(sts_clr_mask), .sts_flags(sts_flags), .acc_valid(acc_valid),
    .acc_direct(acc_direct), .acc_cs(acc_cs), .acc_addr(acc_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_off(out_off), .out_err(out_err)
  );

  typedef struct packed {
    logic        dir;
    logic [1:0]  cs;
    logic [31:0] addr;
    logic [2:0]  hit;
    logic [31:0] off;
    logic        err;
  } vec_t;

  // lookups on the reset map: CS0 [0x40,0x48) CS1 [0x48,0x4C) CS2 [0x4C,0x50)
  localparam vec_t VECS [10] = '{
    '{1'b0, 2'd0, 32'h2000_0010, 3'b001, 32'h0000_0010, 1'b0},
    '{1'b0, 2'd0, 32'h2400_0004, 3'b010, 32'h0000_0004, 1'b0},
    '{1'b0, 2'd0, 32'h2600_0000, 3'b100, 32'h0000_0000, 1'b0},
    '{1'b0, 2'd0, 32'h27FF_FFFF, 3'b100, 32'h01FF_FFFF, 1'b0},
    '{1'b0, 2'd0, 32'h2800_0000, 3'b000, 32'h0000_0000, 1'b1},
    '{1'b0, 2'd0, 32'h1FFF_FFFC, 3'b000, 32'h0000_0000, 1'b1},
    '{1'b1, 2'd1, 32'h0000_0100, 3'b010, 32'h0000_0100, 1'b0},
    '{1'b1, 2'd1, 32'h0200_0008, 3'b010, 32'h0000_0008, 1'b1},
    '{1'b1, 2'd0, 32'h0500_0000, 3'b001, 32'h0100_0000, 1'b1},
    '{1'b1, 2'd3, 32'h0000_0040, 3'b000, 32'h0000_0000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] i, input logic [31:0] exp);
    @(negedge clk);
    reg_idx = i;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk);
    sts_clr_en = 1'b1; sts_clr_mask = m;
    @(negedge clk);
    sts_clr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic d, input logic [1:0] c,
                      input logic [31:0] a, input logic [2:0] eh,
                      input logic [31:0] eo, input logic ee);
    @(negedge clk);
    acc_valid = 1'b1; acc_direct = d; acc_cs = c; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(req, {28'h0, out_valid, out_hit}, {28'h0, 1'b1, eh});
    chk(req, out_off, eo);
    chk(req, {31'h0, out_err}, {31'h0, ee});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R8 R9: quiet after reset
    chk("R8", {29'h0, sts_flags}, 32'h0);
    chk("R9", {31'h0, out_valid}, 32'h0);
    // R1: reset map
    rd_chk("R1", 2'd0, 32'h4840_0000);
    rd_chk("R1", 2'd1, 32'h4C48_0000);
    rd_chk("R1", 2'd2, 32'h504C_0000);
    // R2: index beyond the last CS reads zero
    rd_chk("R2", 2'd3, 32'h0);

    // R9 R10: vector table
    for (int v = 0; v < 10; v++)
      look(VECS[v].dir ? "R10" : "R9", VECS[v].dir, VECS[v].cs, VECS[v].addr,
           VECS[v].hit, VECS[v].off, VECS[v].err);

    // R3: CS0 start forced; size 10 misaligned; overlaps CS1
    wr_seg(2'd0, 32'h4A30_0000);
    chk("R3", {29'h0, sts_flags}, 32'h6);
    rd_chk("R3", 2'd0, 32'h4A40_0000);
    clr(3'b111);
    chk("R8", {29'h0, sts_flags}, 32'h0);
    // R6: touching ranges do not overlap; R1 low bits dropped
    wr_seg(2'd0, 32'h4840_1234);
    chk("R6", {29'h0, sts_flags}, 32'h0);
    rd_chk("R1", 2'd0, 32'h4840_0000);

    // R4: refused writes
    wr_seg(2'd2, 32'h4038_0000);
    chk("R4", {29'h0, sts_flags}, 32'h1);
    rd_chk("R4", 2'd2, 32'h504C_0000);
    clr(3'b001);
    wr_seg(2'd2, 32'h7068_0000);
    chk("R4", {29'h0, sts_flags}, 32'h1);
    rd_chk("R4", 2'd2, 32'h504C_0000);
    clr(3'b001);
    // R4: start exactly at window end accepted
    wr_seg(2'd2, 32'h6160_0000);
    chk("R4", {29'h0, sts_flags}, 32'h0);
    rd_chk("R4", 2'd2, 32'h6160_0000);

    // R5: size 6 at 0x50 misaligned but stored
    wr_seg(2'd2, 32'h5650_0000);
    chk("R5", {29'h0, sts_flags}, 32'h2);
    rd_chk("R5", 2'd2, 32'h5650_0000);
    clr(3'b010);
    // R11: modulo by 6
    look("R11", 1'b1, 2'd2, 32'h0400_0010, 3'b100, 32'h0100_0010, 1'b1);
    look("R11", 1'b1, 2'd2, 32'h0280_0004, 3'b100, 32'h0280_0004, 1'b0);
    look("R9",  1'b0, 2'd0, 32'h2A80_0000, 3'b100, 32'h0280_0000, 1'b0);

    // R6: overlap with CS1, offset from lowest CS
    wr_seg(2'd2, 32'h4C4A_0000);
    chk("R6", {29'h0, sts_flags}, 32'h4);
    rd_chk("R6", 2'd2, 32'h4C4A_0000);
    clr(3'b100);
    look("R6", 1'b0, 2'd0, 32'h2500_0000, 3'b110, 32'h0100_0000, 1'b0);

    // R7: same value (low bits differ only) ignored
    wr_seg(2'd2, 32'h4C4A_00FF);
    chk("R7", {29'h0, sts_flags}, 32'h0);
    rd_chk("R7", 2'd2, 32'h4C4A_0000);

    // R8: event beats a clear in the same cycle
    @(negedge clk);
    reg_wr_en = 1'b1; reg_idx = 2'd2; reg_wdata = 32'h4C48_0000;
    sts_clr_en = 1'b1; sts_clr_mask = 3'b100;
    @(negedge clk);
    reg_wr_en = 1'b0; sts_clr_en = 1'b0;
    chk("R8", {29'h0, sts_flags}, 32'h4);
    clr(3'b100);
    chk("R8", {29'h0, sts_flags}, 32'h0);

    // R2: write to a missing CS changes nothing
    wr_seg(2'd3, 32'h1234_0000);
    chk("R2", {29'h0, sts_flags}, 32'h0);
    rd_chk("R2", 2'd3, 32'h0);
    rd_chk("R2", 2'd2, 32'h4C48_0000);

    // R10: zero-size segment
    wr_seg(2'd2, 32'h4848_0000);
    chk("R5", {29'h0, sts_flags}, 32'h0);
    look("R10", 1'b1, 2'd2, 32'h0000_0010, 3'b100, 32'h0, 1'b1);
    look("R9",  1'b0, 2'd0, 32'h2400_0000, 3'b010, 32'h0, 1'b0);
    // R9: idle cycle clears outputs
    @(negedge clk);
    chk("R9", {28'h0, out_valid, out_hit}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule